// File: doc/BRIEF.md
# Feedback Bitstream Error Comparator

This block compares an incoming 1-bit audio stream with a 1-bit feedback stream taken from the output stage of a switching power amplifier. The analog side samples the speaker-side output once per stream clock and passes a multi-bit level in. The block turns each rise or fall between two consecutive levels into a feedback bit. It pairs that feedback bit with the input bit that caused the step.

Two modes are available. In immediate mode, a mismatch between the previous input bit and the new feedback bit forces the outgoing bit to repeat the previous input bit, which pushes the output back toward the intended direction. In frame mode the stream passes through unchanged.

In both modes the paired bits are collected into two shift containers of `FRAME_LEN` bits. Each time a container fills, the block publishes the XOR error mask and its population count, together with a single-cycle ready pulse, for offline analysis.

Top module: `fb_bitstream_cmp`

## Requirements
- R1: On a stream strobe with a previous sample available, the feedback bit is 1 when the new level is greater than the previous level and 0 when it is smaller.
- R2: When two consecutive levels are equal, the feedback bit repeats the last feedback bit, which is 0 after reset. The first strobe after reset produces no feedback bit: it neither pushes the containers nor corrects.
- R3: With `mode_i`=0 (frame mode), `bit_o` equals the `bit_i` of the latest strobe, registered on that strobe's clock edge.
- R4: With `mode_i`=1 (immediate mode), if a feedback bit exists and differs from the previous strobe's input bit, `bit_o` takes the previous input bit. Otherwise `bit_o` takes the current `bit_i`. Both cases are registered on the strobe edge.
- R5: Every strobe that has a feedback bit pushes one pair (previous input bit, feedback bit). After `FRAME_LEN` pushes, `frame_o` is high for exactly one cycle, starting at the edge of the last push.
- R6: `mask_o` is the bitwise XOR of the two containers. Bit 0 holds the last pair of the frame and bit `FRAME_LEN`-1 holds the first pair. It is held until the next frame.
- R7: `err_cnt_o` is the number of set bits in `mask_o`, updated at the same edge as `mask_o`. It never exceeds `FRAME_LEN`.
- R8: Cycles with `valid_i` low change nothing: `bit_o`, `mask_o` and `err_cnt_o` hold, and `frame_o` stays low.
- R9: `FRAME_LEN` defaults to 32 and also works at 8, with the same frame behaviour.
- R10: While `rst_ni` is low, and after it is released, `bit_o`, `frame_o`, `mask_o` and `err_cnt_o` are 0.
- R11: The containers fill in both modes. Changing `mode_i` in the middle of a frame does not disturb frame alignment or mask content.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| valid_i | input | 1 | Stream clock strobe, one cycle per stream bit |
| bit_i | input | 1 | Incoming stream bit |
| level_i | input | LVL_W | Sampled output level for this strobe |
| mode_i | input | 1 | 0 frame mode (pass-through), 1 immediate correction |
| bit_o | output | 1 | Outgoing (possibly corrected) stream bit |
| frame_o | output | 1 | One-cycle frame-ready pulse |
| mask_o | output | FRAME_LEN | XOR error mask of the last frame |
| err_cnt_o | output | $clog2(FRAME_LEN+1) | Set-bit count of mask_o |

## Verification
Directed ramps that only rise or only fall give feedback that is constantly 1 or constantly 0. Against alternating input bits, this separates a swapped comparison from a correct one and also exposes a reversed mask bit order. Runs of equal levels, including one placed straight after reset, show whether the held feedback value and the missing first feedback bit are handled. A long run of random levels and bits, with mode flips and idle gaps between strobes, is compared pair by pair against an arithmetic model. The same stimulus drives a 32-bit and an 8-bit instance, so frame length, alignment across mode changes and mask counts are checked at both sizes.

// File: rtl/fbc_pkg.sv
package fbc_pkg;
  typedef enum logic {
    MODE_FRAME = 1'b0,
    MODE_IMM   = 1'b1
  } fbc_mode_e;

  function automatic int unsigned cnt_w(int unsigned n);
    return $clog2(n + 1);
  endfunction
endpackage

// File: rtl/fbc_slope_det.sv
module fbc_slope_det #(
  parameter int unsigned LVL_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_i,
  input  logic [LVL_W-1:0] level_i,
  output logic             fb_o,
  output logic             fb_vld_o
);
  logic [LVL_W-1:0] prev_q;
  logic             have_prev_q;
  logic             fb_q;

  always_comb begin
    if (level_i > prev_q)      fb_o = 1'b1;
    else if (level_i < prev_q) fb_o = 1'b0;
    else                       fb_o = fb_q;
  end

  assign fb_vld_o = valid_i & have_prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q      <= '0;
      have_prev_q <= 1'b0;
      fb_q        <= 1'b0;
    end else if (valid_i) begin
      prev_q      <= level_i;
      have_prev_q <= 1'b1;
      if (have_prev_q) fb_q <= fb_o;
    end
  end

  // equal levels keep the held feedback
  p_fb_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && have_prev_q && (level_i == prev_q) |=> fb_q == $past(fb_q));
  p_fb_rise_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && have_prev_q && (level_i > prev_q) |=> fb_q);
endmodule

// File: rtl/fbc_corrector.sv
module fbc_corrector
  import fbc_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      valid_i,
  input  fbc_mode_e mode_i,
  input  logic      bit_i,
  input  logic      prev_bit_i,
  input  logic      fb_i,
  input  logic      fb_vld_i,
  output logic      bit_o
);
  logic mismatch;
  logic bit_d;

  assign mismatch = fb_vld_i & (fb_i != prev_bit_i);

  always_comb begin
    bit_d = bit_i;
    if (mode_i == MODE_IMM && mismatch) bit_d = prev_bit_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      bit_o <= 1'b0;
    else if (valid_i) bit_o <= bit_d;
  end

  p_pass_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && mode_i == MODE_FRAME |=> bit_o == $past(bit_i));
  p_idle_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(bit_o));
endmodule

// File: rtl/fbc_frame_acc.sv
module fbc_frame_acc #(
  parameter int unsigned FRAME_LEN = 32,
  localparam int unsigned CNT_W    = $clog2(FRAME_LEN + 1),
  localparam int unsigned FILL_W   = $clog2(FRAME_LEN)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 push_i,
  input  logic                 in_bit_i,
  input  logic                 fb_bit_i,
  output logic                 frame_o,
  output logic [FRAME_LEN-1:0] mask_o,
  output logic [CNT_W-1:0]     err_cnt_o
);
  localparam logic [FILL_W-1:0] LAST = FILL_W'(FRAME_LEN - 1);

  logic [FRAME_LEN-1:0] in_sr_q, fb_sr_q;
  logic [FRAME_LEN-1:0] in_sr_d, fb_sr_d, mask_d;
  logic [FILL_W-1:0]    fill_q;
  logic [CNT_W-1:0]     pop_d;

  assign in_sr_d = {in_sr_q[FRAME_LEN-2:0], in_bit_i};
  assign fb_sr_d = {fb_sr_q[FRAME_LEN-2:0], fb_bit_i};
  assign mask_d  = in_sr_d ^ fb_sr_d;

  always_comb begin
    pop_d = '0;
    for (int i = 0; i < FRAME_LEN; i++) pop_d = pop_d + CNT_W'(mask_d[i]);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      in_sr_q   <= '0;
      fb_sr_q   <= '0;
      fill_q    <= '0;
      frame_o   <= 1'b0;
      mask_o    <= '0;
      err_cnt_o <= '0;
    end else begin
      frame_o <= 1'b0;
      if (push_i) begin
        in_sr_q <= in_sr_d;
        fb_sr_q <= fb_sr_d;
        if (fill_q == LAST) begin
          fill_q    <= '0;
          frame_o   <= 1'b1;
          mask_o    <= mask_d;
          err_cnt_o <= pop_d;
        end else begin
          fill_q <= fill_q + 1'b1;
        end
      end
    end
  end

  p_frame_pulse_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_o |=> !frame_o);
  p_frame_cause_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(frame_o) |-> $past(push_i));
  p_cnt_bound_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_cnt_o <= CNT_W'(FRAME_LEN));
  p_mask_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !push_i |=> $stable(mask_o) && $stable(err_cnt_o));
endmodule

// File: rtl/fb_bitstream_cmp.sv
module fb_bitstream_cmp
  import fbc_pkg::*;
#(
  parameter int unsigned FRAME_LEN = 32,
  parameter int unsigned LVL_W     = 8,
  localparam int unsigned CNT_W    = $clog2(FRAME_LEN + 1)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 valid_i,
  input  logic                 bit_i,
  input  logic [LVL_W-1:0]     level_i,
  input  logic                 mode_i,
  output logic                 bit_o,
  output logic                 frame_o,
  output logic [FRAME_LEN-1:0] mask_o,
  output logic [CNT_W-1:0]     err_cnt_o
);
  logic      fb, fb_vld;
  logic      prev_bit_q;
  fbc_mode_e mode;

  assign mode = fbc_mode_e'(mode_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      prev_bit_q <= 1'b0;
    else if (valid_i) prev_bit_q <= bit_i;
  end

  fbc_slope_det #(.LVL_W(LVL_W)) u_slope (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .valid_i  (valid_i),
    .level_i  (level_i),
    .fb_o     (fb),
    .fb_vld_o (fb_vld)
  );

  fbc_corrector u_corr (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .valid_i    (valid_i),
    .mode_i     (mode),
    .bit_i      (bit_i),
    .prev_bit_i (prev_bit_q),
    .fb_i       (fb),
    .fb_vld_i   (fb_vld),
    .bit_o      (bit_o)
  );

  fbc_frame_acc #(.FRAME_LEN(FRAME_LEN)) u_acc (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .push_i    (fb_vld),
    .in_bit_i  (prev_bit_q),
    .fb_bit_i  (fb),
    .frame_o   (frame_o),
    .mask_o    (mask_o),
    .err_cnt_o (err_cnt_o)
  );
endmodule

// File: tb/sim_fb_bitstream_cmp.sv
module sim_fb_bitstream_cmp;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic valid = 1'b0, bin = 1'b0, mode = 1'b0;
  logic [7:0] lvl = '0;

  logic bo0, fr0, bo1, fr1;
  logic [31:0] mk0;
  logic [7:0]  mk1;
  logic [5:0]  ec0;
  logic [3:0]  ec1;

  int n_chk = 0, n_bad = 0;

  // model state
  logic [7:0]  m_prev = '0;
  bit          m_have = 0;
  logic        m_fb = 0, m_pin = 0;
  logic [31:0] s32 = '0, f32 = '0, x32 = '0;
  logic [7:0]  s8 = '0, f8 = '0, x8 = '0;
  int          c32 = 0, c8 = 0, p32 = 0, p8 = 0;
  logic        e_bit = 0, e_fr32 = 0, e_fr8 = 0;

  always #4 clk = ~clk;

  fb_bitstream_cmp #(.FRAME_LEN(32), .LVL_W(8)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid), .bit_i(bin), .level_i(lvl),
    .mode_i(mode), .bit_o(bo0), .frame_o(fr0), .mask_o(mk0), .err_cnt_o(ec0));

  fb_bitstream_cmp #(.FRAME_LEN(8), .LVL_W(8)) u1 (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid), .bit_i(bin), .level_i(lvl),
    .mode_i(mode), .bit_o(bo1), .frame_o(fr1), .mask_o(mk1), .err_cnt_o(ec1));

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic int pop(logic [31:0] v);
    int c = 0;
    for (int i = 0; i < 32; i++) c += int'(v[i]);
    return c;
  endfunction

  // one strobe, then gap idle cycles
  task automatic strobe(logic b, logic [7:0] l, logic m, int gap, string tag);
    logic fb;
    bit   fbv;
    fbv = m_have;
    fb  = m_fb;
    if (m_have) begin
      if (l > m_prev)      fb = 1'b1;
      else if (l < m_prev) fb = 1'b0;
      m_fb = fb;
    end
    e_bit  = (m && fbv && (fb != m_pin)) ? m_pin : b;
    e_fr32 = 0;
    e_fr8  = 0;
    if (fbv) begin
      s32 = {s32[30:0], m_pin}; f32 = {f32[30:0], fb};
      s8  = {s8[6:0], m_pin};   f8  = {f8[6:0], fb};
      c32++; c8++;
      if (c32 == 32) begin c32 = 0; e_fr32 = 1; x32 = s32 ^ f32; p32 = pop(x32); end
      if (c8 == 8)   begin c8 = 0;  e_fr8 = 1;  x8 = s8 ^ f8;    p8 = pop({24'd0, x8}); end
    end
    m_pin  = b;
    m_prev = l;
    m_have = 1;

    @(negedge clk);
    valid = 1'b1; bin = b; lvl = l; mode = m;
    @(negedge clk);
    valid = 1'b0;
    chk({tag, " bit_o w32"}, 64'(bo0), 64'(e_bit));
    chk({tag, " bit_o w8 R9"}, 64'(bo1), 64'(e_bit));
    chk("R5 frame pulse w32", 64'(fr0), 64'(e_fr32));
    chk("R9 frame pulse w8", 64'(fr1), 64'(e_fr8));
    chk("R6 mask w32", 64'(mk0), 64'(x32));
    chk("R7 count w32", 64'(ec0), 64'(p32));
    chk("R9 R6 mask w8", 64'(mk1), 64'(x8));
    chk("R9 R7 count w8", 64'(ec1), 64'(p8));
    for (int g = 0; g < gap; g++) begin
      bin = ~bin; lvl = lvl + 8'd3; mode = ~mode;
      @(negedge clk);
      chk("R8 idle bit_o", 64'(bo0), 64'(e_bit));
      chk("R8 idle frame", 64'({fr0, fr1}), 64'(0));
      chk("R8 idle mask", 64'(mk1), 64'(x8));
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R10 reset held", 64'({bo0, fr0, mk0, ec0}), 64'(0));
    rst_n = 1'b1;
    @(negedge clk);
    chk("R10 after release", 64'({bo1, fr1, mk1, ec1}), 64'(0));

    // R2: first strobe then equal levels, immediate mode, bits 1 vs held fb 0
    strobe(1, 8'd50, 1, 0, "R2 first");
    strobe(0, 8'd50, 1, 0, "R2 equal");
    strobe(1, 8'd50, 1, 1, "R2 equal");
    strobe(1, 8'd50, 1, 0, "R2 equal");
    // R1 rising ramp, alternating bits, immediate mode
    for (int i = 0; i < 40; i++) strobe(i[0], 8'(60 + i), 1, 0, "R1 R4 rise");
    // R1 falling ramp, frame mode
    for (int i = 0; i < 40; i++) strobe(i[1], 8'(200 - i), 0, 0, "R1 R3 fall");
    // mixed hold after a rise
    for (int i = 0; i < 20; i++) strobe(i[0] ^ i[2], 8'(100 + (i / 4)), 1, 0, "R2 R4 hold");
    // R11 mode flips every strobe mid-frame
    for (int i = 0; i < 80; i++) strobe(i[1], 8'($urandom_range(0, 7)), i[0], 0, "R11 flip");
    // random sweep with gaps
    for (int i = 0; i < 1500; i++)
      strobe(1'($urandom), 8'($urandom_range(0, 15)), 1'($urandom), $urandom_range(0, 2),
             "R3 R4 rand");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule